// File: doc/BRIEF.md
# Operand-Streaming Command Controller with Sequence Guard

This block is the control front end of a polynomial multiplier accelerator. It reads 16-bit words from an input FIFO, decodes each header word into operand-load requests and an optional operation request, and copies the operand words that follow the header into the core's operand memories. When an operation request is legal, it starts the core. When the core finishes, it returns a status header and then the result coefficients through the output FIFO.

The controller remembers which key operands have been loaded and where a two-phase decryption stands. A request that breaks these rules is not sent to the core. The controller answers it with an error header that carries a numeric code and no payload. Both FIFO sides apply back-pressure: the controller waits whenever there is nothing to read or no room to write, and no word is lost.

States: `ST_IDLE` waits for a header and pops it (IDLE→NEXT). `ST_NEXT` dispatches the work. It goes to the next pending load (NEXT→LOAD). If only an operation is pending, it starts the core when the request is legal (NEXT→RUN) and otherwise prepares an error reply (NEXT→HDR). With nothing pending it goes back to waiting (NEXT→IDLE). `ST_LOAD` copies one operand word per available FIFO word and returns to dispatch after the last one (LOAD→NEXT). `ST_RUN` waits for the core (RUN→HDR). `ST_HDR` writes the status header and then either stops after an error (HDR→IDLE) or goes on to the results (HDR→DATA). `ST_DATA` streams the results and returns to waiting after the last one (DATA→IDLE).

Top module: `fifo_cmd_ctrl`

## Requirements
- R1: After reset, the controller pops nothing, writes nothing, starts nothing, and treats neither key operand as loaded.
- R2: Header bit layout:
  - Bits [15:8] hold the flags. Bit 8 loads the public key, bit 9 loads the private key, bit 10 loads the ciphertext, bit 11 loads the random operand, bit 12 selects decryption, bit 13 requests an operation, bit 14 marks done and bit 15 marks an error.
  - Bits [7:4] hold the error code.
  - Bits [3:0] are reserved and written as zero.
- R3: The operand words follow their header in this fixed order: public key (select 0), private key (select 1), ciphertext (select 2), random operand (select 3). Only the operands whose flags are set are present. A dense operand (select 0 or 2) has N_COEF words and a sparse one (select 1 or 3) has 2·D_WEIGHT words. Each word is written to the operand port at addresses 0 upward.
- R4: A legal operation request gives one core_start pulse. After core_done, the controller writes one status header with bit 14 set, bit 12 equal to the request's decryption flag and error code 0. It then writes N_COEF result words, read at result addresses 0 upward.
- R5: An operation request made before any public-key load completes produces an error header with error code 1. This code takes priority over the other codes.
- R6: A request for the first decryption phase made before any private-key load completes produces error code 2.
- R7: An encryption request made while the second decryption phase is pending produces error code 3. The pending phase is kept.
- R8: A loaded key persists across any number of operations and error replies until reset.
- R9: The controller pops only when the input FIFO is not empty and writes only when the output FIFO is not full. Every operand and result word arrives intact under any stall pattern.
- R10: A header without the operation flag produces no output word.
- R11: The core mode is 0 for encryption and 1 for the first decryption phase. A decryption request made after a successful first phase runs with mode 2. A decryption request made after a successful mode-2 run starts a new first phase.
- R12: An error reply is only the header: bit 15 set, bit 14 clear, bit 12 echoing the request. No core start and no result words go with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_empty | input | 1 | Input FIFO has no word |
| in_rd | output | 1 | Pop the input FIFO |
| in_data | input | 16 | Input FIFO head word |
| out_full | input | 1 | Output FIFO has no room |
| out_wr | output | 1 | Push into the output FIFO |
| out_data | output | 16 | Word pushed into the output FIFO |
| op_wr_en | output | 1 | Operand memory write strobe |
| op_wr_sel | output | 2 | Operand selector (0 pub, 1 priv, 2 ct, 3 rnd) |
| op_wr_addr | output | $clog2(max(N_COEF,2·D_WEIGHT)) | Operand word address |
| op_wr_data | output | 16 | Operand word |
| core_start | output | 1 | One-cycle operation start |
| core_mode | output | 2 | 0 encrypt, 1 decrypt phase one, 2 decrypt phase two |
| core_done | input | 1 | Core finished its operation |
| res_rd_addr | output | $clog2(N_COEF) | Result coefficient address |
| res_rd_data | input | 16 | Result coefficient, combinational read |

## Verification
The hardest states to reach are the ones that depend on history. Code 3 needs a successful first decryption phase followed by an encryption request. Code 2 needs a public key without a private key, which in turn needs a fresh reset partway through the run. The stimulus builds these histories with directed command sequences: reset, partial key loads, then first-phase, encrypt, second-phase and encrypt requests in that order. Seeded random stall patterns on both FIFO flags run underneath, so every load and every result stream is interrupted at unpredictable words.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_LOAD,
        ST_RUN,
        ST_HDR,
        ST_DATA
    } fcc_state_e;

    typedef enum logic [1:0] {
        OPD_PUB  = 2'd0,
        OPD_PRIV = 2'd1,
        OPD_CT   = 2'd2,
        OPD_RND  = 2'd3
    } opd_e;

    typedef enum logic [1:0] {
        MODE_ENC  = 2'd0,
        MODE_DEC1 = 2'd1,
        MODE_DEC2 = 2'd2
    } mode_e;

    localparam int WORD_W    = 16;
    localparam int FLAG_LSB  = 8;
    localparam int BIT_DEC   = 12;
    localparam int BIT_GO    = 13;
    localparam int BIT_DONE  = 14;
    localparam int BIT_ERR   = 15;
    localparam int CODE_LSB  = 4;

    localparam logic [3:0] ERR_NONE     = 4'd0;
    localparam logic [3:0] ERR_NO_PUB   = 4'd1;
    localparam logic [3:0] ERR_NO_PRIV  = 4'd2;
    localparam logic [3:0] ERR_BAD_SEQ  = 4'd3;

    typedef struct packed {
        logic [3:0] loads;   // indexed by opd_e
        logic       dec;
        logic       go;
    } cmd_t;

    function automatic logic is_dense(input logic [1:0] sel);
        return (sel == OPD_PUB) || (sel == OPD_CT);
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic [3:0] code,
                                                       input logic       dec);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_ERR]  = (code != ERR_NONE);
        w[BIT_DONE] = (code == ERR_NONE);
        w[BIT_DEC]  = dec;
        w[CODE_LSB +: 4] = code;
        return w;
    endfunction

endpackage

// File: rtl/fcc_hdr_unpack.sv
module fcc_hdr_unpack
    import fcc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    always_comb begin
        cmd.loads = word[FLAG_LSB +: 4];
        cmd.dec   = word[BIT_DEC];
        cmd.go    = word[BIT_GO];
    end
endmodule

// File: rtl/fcc_word_cnt.sv
module fcc_word_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW:0]   limit,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = ({1'b0, cnt} == (limit - 1'b1));
endmodule

// File: rtl/fcc_seq_guard.sv
module fcc_seq_guard
    import fcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_fin,
    input  logic [1:0] load_sel,
    input  logic       op_commit,
    input  mode_e      commit_mode,
    input  logic       req_dec,
    output logic [3:0] err_code,
    output mode_e      req_mode
);
    logic pub_ok;
    logic priv_ok;
    logic phase2_due;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_ok     <= 1'b0;
            priv_ok    <= 1'b0;
            phase2_due <= 1'b0;
        end else begin
            if (load_fin && (load_sel == OPD_PUB))  pub_ok  <= 1'b1;
            if (load_fin && (load_sel == OPD_PRIV)) priv_ok <= 1'b1;
            if (op_commit) begin
                if (commit_mode == MODE_DEC1)      phase2_due <= 1'b1;
                else if (commit_mode == MODE_DEC2) phase2_due <= 1'b0;
            end
        end
    end

    always_comb begin
        if (!req_dec)        req_mode = MODE_ENC;
        else if (phase2_due) req_mode = MODE_DEC2;
        else                 req_mode = MODE_DEC1;

        if (!pub_ok)                              err_code = ERR_NO_PUB;
        else if (req_dec && !phase2_due && !priv_ok) err_code = ERR_NO_PRIV;
        else if (!req_dec && phase2_due)          err_code = ERR_BAD_SEQ;
        else                                      err_code = ERR_NONE;
    end
endmodule

// File: rtl/fifo_cmd_ctrl.sv
module fifo_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int N_COEF   = 16,
    parameter int D_WEIGHT = 3,
    localparam int IDX_CNT = 2 * D_WEIGHT,
    localparam int MAX_LEN = (N_COEF > IDX_CNT) ? N_COEF : IDX_CNT,
    localparam int AW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int RW      = (N_COEF > 1) ? $clog2(N_COEF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_empty,
    output logic              in_rd,
    input  logic [15:0]       in_data,
    input  logic              out_full,
    output logic              out_wr,
    output logic [15:0]       out_data,
    output logic              op_wr_en,
    output logic [1:0]        op_wr_sel,
    output logic [AW-1:0]     op_wr_addr,
    output logic [15:0]       op_wr_data,
    output logic              core_start,
    output logic [1:0]        core_mode,
    input  logic              core_done,
    output logic [RW-1:0]     res_rd_addr,
    input  logic [15:0]       res_rd_data
);
    fcc_state_e state, nxt;

    cmd_t       hdr_cmd;
    logic [3:0] pend_ld;
    logic       pend_go;
    logic       pend_dec;
    logic [1:0] cur_sel;
    logic [1:0] first_ld;
    logic [3:0] err_q;
    mode_e      mode_q;

    logic [3:0] grd_err;
    mode_e      grd_mode;

    logic          cnt_clr, cnt_inc, cnt_last;
    logic [AW-1:0] cnt;
    logic [AW:0]   cnt_limit;
    logic          load_fin, op_commit;

    fcc_hdr_unpack u_unpack (
        .word (in_data),
        .cmd  (hdr_cmd)
    );

    fcc_seq_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_fin    (load_fin),
        .load_sel    (cur_sel),
        .op_commit   (op_commit),
        .commit_mode (mode_q),
        .req_dec     (pend_dec),
        .err_code    (grd_err),
        .req_mode    (grd_mode)
    );

    fcc_word_cnt #(.CW(AW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (cnt_limit),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    // lowest pending operand goes first (fixed stream order)
    always_comb begin
        first_ld = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (pend_ld[i]) first_ld = 2'(i);
        end
    end

    always_comb begin
        if (state == ST_LOAD) begin
            cnt_limit = is_dense(cur_sel) ? (AW+1)'(N_COEF) : (AW+1)'(IDX_CNT);
        end else begin
            cnt_limit = (AW+1)'(N_COEF);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and next state
    always_comb begin
        nxt        = state;
        in_rd      = 1'b0;
        out_wr     = 1'b0;
        out_data   = '0;
        op_wr_en   = 1'b0;
        core_start = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        load_fin   = 1'b0;
        op_commit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!in_empty) begin
                    in_rd = 1'b1;
                    nxt   = ST_NEXT;
                end
            end
            ST_NEXT: begin
                cnt_clr = 1'b1;
                if (|pend_ld) begin
                    nxt = ST_LOAD;
                end else if (pend_go) begin
                    if (grd_err == ERR_NONE) begin
                        core_start = 1'b1;
                        nxt        = ST_RUN;
                    end else begin
                        nxt = ST_HDR;
                    end
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_LOAD: begin
                if (!in_empty) begin
                    in_rd    = 1'b1;
                    op_wr_en = 1'b1;
                    cnt_inc  = 1'b1;
                    if (cnt_last) begin
                        load_fin = 1'b1;
                        nxt      = ST_NEXT;
                    end
                end
            end
            ST_RUN: begin
                if (core_done) begin
                    op_commit = 1'b1;
                    nxt       = ST_HDR;
                end
            end
            ST_HDR: begin
                if (!out_full) begin
                    out_wr   = 1'b1;
                    out_data = pack_status(err_q, pend_dec);
                    cnt_clr  = 1'b1;
                    nxt      = (err_q != ERR_NONE) ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (!out_full) begin
                    out_wr   = 1'b1;
                    out_data = res_rd_data;
                    cnt_inc  = 1'b1;
                    if (cnt_last) nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // command bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ld  <= '0;
            pend_go  <= 1'b0;
            pend_dec <= 1'b0;
            cur_sel  <= 2'd0;
            err_q    <= ERR_NONE;
            mode_q   <= MODE_ENC;
        end else begin
            if (state == ST_IDLE && in_rd) begin
                pend_ld  <= hdr_cmd.loads;
                pend_go  <= hdr_cmd.go;
                pend_dec <= hdr_cmd.dec;
            end
            if (state == ST_NEXT) begin
                if (|pend_ld) begin
                    cur_sel           <= first_ld;
                    pend_ld[first_ld] <= 1'b0;
                end else if (pend_go) begin
                    pend_go <= 1'b0;
                    err_q   <= grd_err;
                    mode_q  <= grd_mode;
                end
            end
        end
    end

    assign op_wr_sel   = cur_sel;
    assign op_wr_addr  = cnt;
    assign op_wr_data  = in_data;
    assign core_mode   = (state == ST_NEXT) ? grd_mode : mode_q;
    assign res_rd_addr = cnt[RW-1:0];

endmodule

// File: rtl/fifo_cmd_ctrl_chk.sv
module fifo_cmd_ctrl_chk #(
    parameter int N_COEF   = 16,
    parameter int D_WEIGHT = 3,
    parameter int AW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_empty,
    input logic          in_rd,
    input logic          out_full,
    input logic          out_wr,
    input logic [15:0]   out_data,
    input logic          op_wr_en,
    input logic [1:0]    op_wr_sel,
    input logic [AW-1:0] op_wr_addr,
    input logic          core_start,
    input logic [1:0]    core_mode
);
    localparam int IDX_CNT = 2 * D_WEIGHT;

    logic [31:0] opd_limit;
    assign opd_limit = (op_wr_sel[0] == 1'b0) ? 32'(N_COEF) : 32'(IDX_CNT);

    AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !in_empty); // R9
    AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> !out_full); // R9
    AST_OPWR_IS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr_en |-> in_rd); // R3
    AST_OPWR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr_en |-> (32'(op_wr_addr) < opd_limit)); // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R4
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (!out_wr && !in_rd)); // R4
    AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && out_data[15]) |-> (out_data[7:4] inside {4'd1, 4'd2, 4'd3})); // R12
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (core_mode != 2'd3)); // R11
endmodule

bind fifo_cmd_ctrl fifo_cmd_ctrl_chk #(
    .N_COEF(N_COEF), .D_WEIGHT(D_WEIGHT), .AW(AW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd),
    .out_full(out_full), .out_wr(out_wr), .out_data(out_data),
    .op_wr_en(op_wr_en), .op_wr_sel(op_wr_sel), .op_wr_addr(op_wr_addr),
    .core_start(core_start), .core_mode(core_mode)
);

// File: tb/fifo_cmd_ctrl_tb_top.sv
module fifo_cmd_ctrl_tb_top;
    localparam int N  = 16;
    localparam int DW = 3;
    localparam int NI = 2 * DW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_empty, in_rd, out_full, out_wr;
    logic [15:0] in_data, out_data, op_wr_data, res_rd_data;
    logic        op_wr_en, core_start, core_done;
    logic [1:0]  op_wr_sel, core_mode;
    logic [3:0]  op_wr_addr, res_rd_addr;

    always #2.5 clk = ~clk;

    fifo_cmd_ctrl #(.N_COEF(N), .D_WEIGHT(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd),
        .in_data(in_data), .out_full(out_full), .out_wr(out_wr),
        .out_data(out_data), .op_wr_en(op_wr_en), .op_wr_sel(op_wr_sel),
        .op_wr_addr(op_wr_addr), .op_wr_data(op_wr_data),
        .core_start(core_start), .core_mode(core_mode), .core_done(core_done),
        .res_rd_addr(res_rd_addr), .res_rd_data(res_rd_data)
    );

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // input FIFO model
    logic [15:0] inq [0:1023];
    int wptr = 0, rptr = 0;
    logic stall_in = 1'b0;
    assign in_empty = (rptr == wptr) || stall_in;
    assign in_data  = inq[rptr % 1024];
    always @(posedge clk) if (in_rd) rptr <= rptr + 1;

    // output FIFO model
    logic [15:0] outq [0:1023];
    int outcnt = 0;
    always @(posedge clk) if (out_wr && !out_full) begin
        outq[outcnt % 1024] <= out_data;
        outcnt <= outcnt + 1;
    end

    always @(negedge clk) begin
        stall_in <= ($urandom % 4) == 0;
        out_full <= ($urandom % 4) == 0;
    end

    // operand memory model
    logic [15:0] got [0:3][0:15];
    always @(posedge clk) if (op_wr_en) got[op_wr_sel][op_wr_addr] <= op_wr_data;

    // core model
    int nstart = 0;
    logic [1:0] seen_mode = 2'd0;
    int dly = 0;
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (core_start) begin
            nstart    <= nstart + 1;
            seen_mode <= core_mode;
            dly       <= 3;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) core_done <= 1'b1;
        end
    end

    function automatic logic [15:0] exp_res(int serial, logic [1:0] m, int a);
        return 16'((serial * 977) ^ (a * 131) ^ (int'(m) << 13));
    endfunction
    assign res_rd_data = exp_res(nstart, seen_mode, int'(res_rd_addr));

    logic [15:0] sent [0:3][0:15];

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [15:0] w);
        @(negedge clk);
        inq[wptr % 1024] = w;
        wptr++;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 5000 && rptr != wptr; i++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_load(logic [3:0] mask);
        int base = outcnt;
        push(16'(mask) << 8);
        for (int s = 0; s < 4; s++) begin
            if (mask[s]) begin
                int len = (s % 2 == 0) ? N : NI;
                for (int i = 0; i < len; i++) begin
                    sent[s][i] = 16'($urandom);
                    push(sent[s][i]);
                end
            end
        end
        wait_drain();
        for (int s = 0; s < 4; s++) begin
            if (mask[s]) begin
                int len = (s % 2 == 0) ? N : NI;
                int bad = 0;
                for (int i = 0; i < len; i++) if (got[s][i] !== sent[s][i]) bad++;
                check(bad == 0, "R3/R9 operand words", bad, 0);
            end
        end
        check(outcnt == base, "R10 no output after load-only header", outcnt - base, 0);
    endtask

    task automatic run_go(bit dec, logic [3:0] code, logic [1:0] mode);
        int base = outcnt;
        int st0  = nstart;
        int want = (code == 0) ? 1 + N : 1;
        logic [15:0] eh;
        push(16'h2000 | (16'(dec) << 12));
        for (int i = 0; i < 5000 && outcnt < base + want; i++) @(negedge clk);
        repeat (12) @(negedge clk);
        check(outcnt == base + want, "R4/R12 reply length", outcnt - base, want);
        eh = 16'(dec) << 12 | 16'(code) << 4;
        eh = eh | ((code == 0) ? 16'h4000 : 16'h8000);
        check(outq[base % 1024] == eh,
              code == 0 ? "R2/R4 status header" :
              code == 1 ? "R5 missing public key" :
              code == 2 ? "R6 missing private key" : "R7 bad sequence",
              outq[base % 1024], eh);
        if (code == 0) begin
            int bad = 0;
            check(nstart == st0 + 1, "R4 one core start", nstart - st0, 1);
            check(seen_mode == mode, "R11 core mode", seen_mode, mode);
            for (int a = 0; a < N; a++)
                if (outq[(base + 1 + a) % 1024] !== exp_res(nstart, mode, a)) bad++;
            check(bad == 0, "R4/R9 result words", bad, 0);
        end else begin
            check(nstart == st0, "R12 no core start on error", nstart - st0, 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        do_reset();
        check(in_rd == 1'b0 && out_wr == 1'b0 && core_start == 1'b0,
              "R1 quiet after reset", {in_rd, out_wr, core_start}, 0);
        run_go(1'b0, 4'd1, 2'd0);            // R1 R5: nothing loaded yet
        send_load(4'b1011);                  // R3 pub, priv, rnd order
        run_go(1'b0, 4'd0, 2'd0);            // R4 encrypt
        send_load(4'b0100);                  // ciphertext only
        run_go(1'b1, 4'd0, 2'd1);            // R11 phase one
        run_go(1'b0, 4'd3, 2'd0);            // R7 encrypt while phase two due
        run_go(1'b1, 4'd0, 2'd2);            // R7 R11 pending phase kept
        run_go(1'b0, 4'd0, 2'd0);            // R8 keys persist
        run_go(1'b1, 4'd0, 2'd1);            // R11 new phase one
        send_load(4'b1111);                  // R3 all four
        run_go(1'b1, 4'd0, 2'd2);            // R8 phase two after reload
        do_reset();
        run_go(1'b1, 4'd1, 2'd0);            // R5 priority over code 2
        send_load(4'b0001);
        run_go(1'b1, 4'd2, 2'd0);            // R6 no private key
        run_go(1'b0, 4'd0, 2'd0);            // R8 pub still there
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule